// File: doc/BRIEF.md
# Vector Condition-Code Predication Unit

This unit decides, each cycle, which of the four lanes of a vector result (x, y, z, w) may be committed. It keeps a small condition-code register that holds, per lane, a negative flag and a zero flag. When an instruction asks for a predicate test, each lane picks one condition-code lane through its own swizzle selector. It evaluates a 3-bit relation against that lane's flags and combines the outcome with the instruction's write mask.

The same instruction may also refresh the condition-code register from the sign and zero state of its own result. Only the lanes that are actually written are refreshed, and the new flags take effect at the next clock edge. A test inside the updating instruction therefore sees the old flags. The write enables are combinational from the registered flags and the current instruction fields. The arithmetic that produces the result and the register file that receives it sit outside this unit.

The unit has no sequencing states of its own. Its single state element is the flag register, with two transitions per lane: hold, or load from the written result.

Top module: `ccpred_unit`

## Requirements
- R1: After reset every condition-code lane holds the flags of the value zero (negative = 0, zero = 1), so an equality test passes and a less-than test fails on all lanes.
- R2: With `test_en` low, `wr_en` equals `wr_mask`, whatever the relation, swizzle and flags are.
- R3: With `test_en` high, lane i passes when the relation holds on its selected flags (n, z). The relation is coded on `cond_code`: 0 never, 1 n, 2 z, 3 n or z, 4 neither n nor z, 5 not z, 6 not n, 7 always.
- R4: Lane i reads condition-code lane `cond_swz[2i+1:2i]` (0 = x, 1 = y, 2 = z, 3 = w), with lane x in bit 0 of every 4-bit vector.
- R5: `wr_en[i]` is set only when `wr_mask[i]` is set and lane i passes the test. A lane with a clear mask bit is never enabled.
- R6: While `upd_en` is low, the result flags are ignored and the condition-code register keeps its contents across clock edges.
- R7: With `upd_en` high, only the lanes with `wr_en[i]` set load `res_neg[i]` and `res_zero[i]` at the clock edge. The other lanes keep their flags, including when the test itself blocks the write.
- R8: A test in the same cycle as an update uses the flags held before that edge. The new flags are seen by the test from the following cycle on.
- R9: Code 0 gives `wr_en` = 0 and code 7 gives `wr_en` = `wr_mask` for any flag contents and swizzle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Apply the predicate test this cycle |
| cond_code | input | 3 | Relation code (see R3) |
| cond_swz | input | 8 | Per-lane 2-bit condition-code lane selectors |
| wr_mask | input | 4 | Per-lane write mask |
| upd_en | input | 1 | Refresh condition codes from the result |
| res_neg | input | 4 | Per-lane negative flag of the result |
| res_zero | input | 4 | Per-lane zero flag of the result |
| wr_en | output | 4 | Final per-lane write enables |

## Verification
The bench loads every combination of positive, zero and negative flags across the four lanes. For each one it sweeps all eight relations against all 256 swizzle words with a varying mask. A swizzle wired to the wrong lane, or a relation with a swapped code such as less-or-equal against greater-or-equal, would then show up as a wrong lane enable. Partial updates through a sparse mask and through a blocked test are aimed at a design that refreshes every lane whenever `upd_en` is set; such a design would overwrite flags the instruction never wrote. The update cycle itself is sampled before the edge, which catches a design that forwards the fresh flags into its own test.

// File: rtl/ccpred_pkg.sv
package ccpred_pkg;

    // Relation applied to one selected flag pair
    typedef enum logic [2:0] {
        REL_NEVER  = 3'd0,
        REL_NEG    = 3'd1,
        REL_ZERO   = 3'd2,
        REL_NONPOS = 3'd3,
        REL_POS    = 3'd4,
        REL_NZERO  = 3'd5,
        REL_NONNEG = 3'd6,
        REL_ALWAYS = 3'd7
    } cc_rel_e;

    // True when the relation holds for the flags (neg, zero)
    function automatic logic rel_holds(cc_rel_e rel, logic neg, logic zero);
        logic r;
        unique case (rel)
            REL_NEVER:  r = 1'b0;
            REL_NEG:    r = neg;
            REL_ZERO:   r = zero;
            REL_NONPOS: r = neg | zero;
            REL_POS:    r = ~neg & ~zero;
            REL_NZERO:  r = ~zero;
            REL_NONNEG: r = ~neg;
            REL_ALWAYS: r = 1'b1;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccpred_lane.sv
module ccpred_lane
    import ccpred_pkg::*;
#(
    parameter int NUM_COMP = 4,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_COMP-1:0] cc_neg,
    input  logic [NUM_COMP-1:0] cc_zero,
    input  logic [SEL_W-1:0]    sel,
    input  cc_rel_e             rel,
    input  logic                test_en,
    input  logic                mask_bit,
    output logic                en
);

    logic pick_neg;
    logic pick_zero;
    logic pass;

    always_comb begin
        pick_neg  = cc_neg[sel];
        pick_zero = cc_zero[sel];
        pass      = test_en ? rel_holds(rel, pick_neg, pick_zero) : 1'b1;
        en        = mask_bit & pass;
    end

endmodule

// File: rtl/ccpred_ccreg.sv
module ccpred_ccreg #(
    parameter int NUM_COMP = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [NUM_COMP-1:0] lane_wr,
    input  logic [NUM_COMP-1:0] res_neg,
    input  logic [NUM_COMP-1:0] res_zero,
    output logic [NUM_COMP-1:0] cc_neg_q,
    output logic [NUM_COMP-1:0] cc_zero_q
);

    logic [NUM_COMP-1:0] load;
    logic [NUM_COMP-1:0] neg_d;
    logic [NUM_COMP-1:0] zero_d;

    // next-state: each lane either holds or loads from the written result
    always_comb begin
        load   = {NUM_COMP{upd_en}} & lane_wr;
        neg_d  = (load & res_neg)  | (~load & cc_neg_q);
        zero_d = (load & res_zero) | (~load & cc_zero_q);
    end

    // state register: resets to the flags of a zero value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_neg_q  <= '0;
            cc_zero_q <= '1;
        end else begin
            cc_neg_q  <= neg_d;
            cc_zero_q <= zero_d;
        end
    end

endmodule

// File: rtl/ccpred_unit.sv
module ccpred_unit
    import ccpred_pkg::*;
#(
    parameter int NUM_COMP = 4,
    localparam int SEL_W   = $clog2(NUM_COMP),
    localparam int SWZ_W   = NUM_COMP * SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                test_en,
    input  logic [2:0]          cond_code,
    input  logic [SWZ_W-1:0]    cond_swz,
    input  logic [NUM_COMP-1:0] wr_mask,
    input  logic                upd_en,
    input  logic [NUM_COMP-1:0] res_neg,
    input  logic [NUM_COMP-1:0] res_zero,
    output logic [NUM_COMP-1:0] wr_en
);

    cc_rel_e             rel;
    logic [NUM_COMP-1:0] cc_neg_q;
    logic [NUM_COMP-1:0] cc_zero_q;

    assign rel = cc_rel_e'(cond_code);

    for (genvar i = 0; i < NUM_COMP; i++) begin : g_lane
        ccpred_lane #(
            .NUM_COMP(NUM_COMP),
            .SEL_W   (SEL_W)
        ) u_lane (
            .cc_neg  (cc_neg_q),
            .cc_zero (cc_zero_q),
            .sel     (cond_swz[i*SEL_W +: SEL_W]),
            .rel     (rel),
            .test_en (test_en),
            .mask_bit(wr_mask[i]),
            .en      (wr_en[i])
        );
    end

    ccpred_ccreg #(
        .NUM_COMP(NUM_COMP)
    ) u_ccreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (upd_en),
        .lane_wr  (wr_en),
        .res_neg  (res_neg),
        .res_zero (res_zero),
        .cc_neg_q (cc_neg_q),
        .cc_zero_q(cc_zero_q)
    );

endmodule

// File: rtl/ccpred_unit_chk.sv
module ccpred_unit_chk #(
    parameter int NUM_COMP = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                test_en,
    input logic [2:0]          cond_code,
    input logic [NUM_COMP-1:0] wr_mask,
    input logic                upd_en,
    input logic [NUM_COMP-1:0] res_neg,
    input logic [NUM_COMP-1:0] res_zero,
    input logic [NUM_COMP-1:0] wr_en,
    input logic [NUM_COMP-1:0] cc_neg_q,
    input logic [NUM_COMP-1:0] cc_zero_q
);

    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en & ~wr_mask) == '0);

    assert_test_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> wr_en == wr_mask);

    assert_never_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && cond_code == 3'd0) |-> wr_en == '0);

    assert_always_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && cond_code == 3'd7) |-> wr_en == wr_mask);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ($stable(cc_neg_q) && $stable(cc_zero_q)));

    assert_load_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ((((cc_neg_q ^ $past(res_neg)) | (cc_zero_q ^ $past(res_zero)))
                     & $past(wr_en)) == '0));

    assert_keep_unwritten_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> ((((cc_neg_q ^ $past(cc_neg_q)) | (cc_zero_q ^ $past(cc_zero_q)))
                     & ~$past(wr_en)) == '0));

endmodule

bind ccpred_unit ccpred_unit_chk #(.NUM_COMP(NUM_COMP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .cond_code(cond_code),
    .wr_mask  (wr_mask),
    .upd_en   (upd_en),
    .res_neg  (res_neg),
    .res_zero (res_zero),
    .wr_en    (wr_en),
    .cc_neg_q (cc_neg_q),
    .cc_zero_q(cc_zero_q)
);

// File: tb/sim_ccpred_unit.sv
`timescale 1ns/1ps
module sim_ccpred_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       test_en = 1'b0;
    logic [2:0] cond_code = '0;
    logic [7:0] cond_swz = 8'hE4;
    logic [3:0] wr_mask = '0;
    logic       upd_en = 1'b0;
    logic [3:0] res_neg = '0;
    logic [3:0] res_zero = '0;
    logic [3:0] wr_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // bench model of the flag register
    logic [3:0] m_neg;
    logic [3:0] m_zero;

    always #5 clk = ~clk;

    ccpred_unit u0 (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .cond_code(cond_code),
        .cond_swz(cond_swz), .wr_mask(wr_mask), .upd_en(upd_en),
        .res_neg(res_neg), .res_zero(res_zero), .wr_en(wr_en)
    );

    function automatic logic rel_ok(int c, logic n, logic z);
        case (c)
            0: return 1'b0;
            1: return n;
            2: return z;
            3: return n | z;
            4: return !n && !z;
            5: return !z;
            6: return !n;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] expect_en(logic te, int c, logic [7:0] swz, logic [3:0] msk);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) begin
            int s = int'(swz[2*i +: 2]);
            r[i] = msk[i] & (te ? rel_ok(c, m_neg[s], m_zero[s]) : 1'b1);
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: wr_en=%b expected %b (cond=%0d swz=%h mask=%b te=%b)",
                     tag, got, exp, cond_code, cond_swz, wr_mask, test_en);
        end
    endtask

    // one clocked instruction; inputs set after a falling edge
    task automatic step(logic te, int c, logic [7:0] swz, logic [3:0] msk,
                        logic up, logic [3:0] rn, logic [3:0] rz);
        logic [3:0] en_now;
        @(negedge clk);
        test_en = te; cond_code = 3'(c); cond_swz = swz; wr_mask = msk;
        upd_en = up; res_neg = rn; res_zero = rz;
        #1;
        en_now = expect_en(te, c, swz, msk);
        @(posedge clk);
        if (up) begin
            m_neg  = (m_neg  & ~en_now) | (rn & en_now);
            m_zero = (m_zero & ~en_now) | (rz & en_now);
        end
        #1;
        upd_en = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_neg  = 4'b0000;
        m_zero = 4'b1111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset flags are those of zero
        test_en = 1'b1; cond_swz = 8'hE4; wr_mask = 4'hF;
        cond_code = 3'd2; #1;
        chk("R1 eq after reset", wr_en, 4'hF);
        cond_code = 3'd1; #1;
        chk("R1 lt after reset", wr_en, 4'h0);

        // R2: test disabled passes mask through
        test_en = 1'b0; cond_code = 3'd0; wr_mask = 4'b1010; #1;
        chk("R2 test off", wr_en, 4'b1010);

        // R6: update disabled, flags ignored across an edge
        step(1'b0, 0, 8'hE4, 4'hF, 1'b0, 4'hF, 4'h0);
        test_en = 1'b1; cond_code = 3'd2; wr_mask = 4'hF; cond_swz = 8'hE4; #1;
        chk("R6 flags ignored", wr_en, 4'hF);

        // load all lanes negative, then check R8 on a same-cycle update
        step(1'b0, 0, 8'hE4, 4'hF, 1'b1, 4'hF, 4'h0);
        @(negedge clk);
        test_en = 1'b1; cond_code = 3'd1; cond_swz = 8'hE4; wr_mask = 4'hF;
        upd_en = 1'b1; res_neg = 4'h0; res_zero = 4'hF; #1;
        chk("R8 old flags in update cycle", wr_en, 4'hF);
        @(posedge clk);
        m_neg = 4'h0; m_zero = 4'hF;
        #1; upd_en = 1'b0;
        @(negedge clk);
        cond_code = 3'd2; #1;
        chk("R8 new flags next cycle", wr_en, 4'hF);

        // R7: sparse mask updates only written lanes
        step(1'b0, 0, 8'hE4, 4'b0101, 1'b1, 4'hF, 4'h0);
        @(negedge clk);
        test_en = 1'b1; cond_code = 3'd1; cond_swz = 8'hE4; wr_mask = 4'hF; #1;
        chk("R7 sparse update neg lanes", wr_en, 4'b0101);
        cond_code = 3'd2; #1;
        chk("R7 sparse update zero lanes", wr_en, 4'b1010);

        // R7: blocked test (code 0) prevents any update
        step(1'b1, 0, 8'hE4, 4'hF, 1'b1, 4'h0, 4'h0);
        @(negedge clk);
        test_en = 1'b1; cond_code = 3'd1; cond_swz = 8'hE4; wr_mask = 4'hF; #1;
        chk("R7 blocked update keeps flags", wr_en, 4'b0101);

        // R4: broadcast swizzles read a single lane
        cond_swz = 8'h00; #1;
        chk("R4 broadcast x", wr_en, 4'hF);
        cond_swz = 8'h55; #1;
        chk("R4 broadcast y", wr_en, 4'h0);

        // R3 R4 R5 R9: sweep flag patterns, relations, swizzles
        for (int p = 0; p < 81; p++) begin
            logic [3:0] rn, rz;
            int q = p;
            for (int i = 0; i < 4; i++) begin
                rn[i] = (q % 3) == 2;
                rz[i] = (q % 3) == 1;
                q = q / 3;
            end
            step(1'b0, 0, 8'hE4, 4'hF, 1'b1, rn, rz);
            test_en = 1'b1;
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 256; s++) begin
                    cond_code = 3'(c);
                    cond_swz  = 8'(s);
                    wr_mask   = 4'(p + s + c);
                    #1;
                    chk("R3 R4 R5 R9 sweep", wr_en,
                        expect_en(1'b1, c, 8'(s), 4'(p + s + c)));
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule